// File: doc/BRIEF.md
# Graphics Configuration Register Bank

This block stores a bank of 768 configuration words, each 32 bits wide. A drawing engine reads these words as settings. There are two ways to reach the bank.

- **Bus port.** A memory-mapped bus port takes absolute byte addresses. It accepts only the 3 KiB window that starts at 0x1EF01000. Inside that window, one word-aligned slot maps to each register, and a bus write always replaces the whole word.
- **Index port.** A command processor can address a register directly by its number. It also supplies a 32-bit merge mask, so that only the masked bits take the new data and the other bits keep their current value.

Both ports are combinational on the read side: the addressed word appears in the same cycle that the request is valid, and a write lands on the next clock edge. If a request misses the window, the bus port flags it at once. If a write misses the bank on either port, it sets a sticky error flag. That flag holds until a dedicated clear input removes it. When both ports want to write in the same cycle, the index port wins and the bus port is held off through its ready signal.

Top module: `gfx_cfg_regfile`

## Requirements
- R1: After reset, and after any later reset, every register reads as zero and the sticky error flag is low.
- R2: A bus byte address A with 0x1EF01000 <= A < 0x1EF01C00 selects register (A - 0x1EF01000) >> 2. The two low address bits are ignored. An accepted bus write replaces all 32 bits of that register.
- R3: While busValid is high and the address is inside the window, busRdata shows the selected register in the same cycle. Otherwise busRdata is zero.
- R4: A bus request whose address is outside the window raises busErr in the same cycle and returns zero data. If that request is an accepted write, it changes no register and sets the sticky error flag on the next edge.
- R5: An index-port write to index N < 768 stores (old AND NOT idxMask) OR (idxWdata AND idxMask) in register N. Mask bit i set to 1 means bit i takes the new data.
- R6: An index of 768 or more is out of range. A read of it returns zero on idxRdata. A write to it changes no register and sets the sticky error flag on the next edge.
- R7: The sticky error flag stays high until errClr is sampled high, and it is low on the edge after that. If a new error arrives in the same cycle as errClr, the flag stays set.
- R8: A read of a register in the same cycle as a write to it returns the old value. The new value is seen from the next cycle onward.
- R9: idxReady is always high. busReady is low in exactly the cycles in which the index port requests a write. While busReady is low, a bus write changes nothing and cannot set the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus request valid |
| busReady | output | 1 | Bus request accepted this cycle |
| busWrite | input | 1 | 1 = bus write, 0 = bus read |
| busAddr | input | 32 | Absolute byte address |
| busWdata | input | 32 | Bus write data |
| busRdata | output | 32 | Bus read data, same cycle |
| busErr | output | 1 | Bus address outside the window |
| idxValid | input | 1 | Index request valid |
| idxReady | output | 1 | Index request accepted (always high) |
| idxWrite | input | 1 | 1 = masked write, 0 = read |
| idxIndex | input | 12 | Register number |
| idxMask | input | 32 | Per-bit merge mask |
| idxWdata | input | 32 | Index write data |
| idxRdata | output | 32 | Index read data, same cycle |
| errClr | input | 1 | Clears the sticky error flag |
| errSticky | output | 1 | Sticky flag for rejected writes |

## Verification
The assertions assume the following about the inputs:
- The request inputs are steady around each rising clock edge.
- Address and index values are known whenever their valid is high.
- errClr is a level that the block samples on the clock edge.

The stimulus changes every input only on falling edges. It mixes addresses inside, just below and just above the window, and indices on both sides of 768. It also drives cycles with both ports active, including a bus write blocked by an index write and an error arriving together with a clear. A behavioural model of the bank predicts each output before the edge.

// File: rtl/gfx_cfg_pkg.sv
package gfx_cfg_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NUM_REGS  = 768;
  localparam int unsigned IDX_W     = 12;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned SLOT_W    = $clog2(NUM_REGS);
  localparam int unsigned BYTES_PER = DATA_W / 8;
  localparam int unsigned BYTE_SH   = $clog2(BYTES_PER);
  localparam logic [ADDR_W-1:0] WIN_BASE  = 32'h1EF0_1000;
  localparam logic [ADDR_W-1:0] WIN_BYTES = ADDR_W'(NUM_REGS * BYTES_PER);

  typedef struct packed {
    logic              wrEn;
    logic [SLOT_W-1:0] wrSlot;
    logic [DATA_W-1:0] wrMask;
    logic [DATA_W-1:0] wrData;
    logic              errSet;
    logic              errClr;
    logic              busRdEn;
    logic [SLOT_W-1:0] busRdSlot;
    logic              idxRdEn;
    logic [SLOT_W-1:0] idxRdSlot;
  } cfgStrobe_t;
endpackage

// File: rtl/gfx_cfg_ctrl.sv
module gfx_cfg_ctrl
  import gfx_cfg_pkg::*;
(
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic              busReady,
  output logic              busErr,
  input  logic              idxValid,
  input  logic              idxWrite,
  input  logic [IDX_W-1:0]  idxIndex,
  input  logic [DATA_W-1:0] idxMask,
  input  logic [DATA_W-1:0] idxWdata,
  output logic              idxReady,
  input  logic              errClr,
  output cfgStrobe_t        strobe
);
  logic [ADDR_W-1:0] busOffset;
  logic              busInWin;
  logic              busAccept;
  logic [SLOT_W-1:0] busSlot;
  logic              idxInRange;
  logic              idxWrReq;
  logic              idxWrOk;
  logic              busWrOk;

  always_comb begin
    busOffset  = busAddr - WIN_BASE;
    busInWin   = (busAddr >= WIN_BASE) && (busOffset < WIN_BYTES);
    busSlot    = busOffset[SLOT_W+BYTE_SH-1:BYTE_SH];
    idxInRange = idxIndex < IDX_W'(NUM_REGS);
    idxWrReq   = idxValid && idxWrite;
    idxReady   = 1'b1;
    busReady   = !idxWrReq;
    busAccept  = busValid && busReady;
    busErr     = busValid && !busInWin;
    idxWrOk    = idxWrReq && idxInRange;
    busWrOk    = busAccept && busWrite && busInWin;
  end

  always_comb begin
    strobe           = '0;
    strobe.wrEn      = idxWrOk || busWrOk;
    strobe.wrSlot    = idxWrOk ? idxIndex[SLOT_W-1:0] : busSlot;
    strobe.wrMask    = idxWrOk ? idxMask : '1;
    strobe.wrData    = idxWrOk ? idxWdata : busWdata;
    strobe.errSet    = (idxWrReq && !idxInRange) ||
                       (busAccept && busWrite && !busInWin);
    strobe.errClr    = errClr;
    strobe.busRdEn   = busValid && busInWin;
    strobe.busRdSlot = busSlot;
    strobe.idxRdEn   = idxValid && idxInRange;
    strobe.idxRdSlot = idxIndex[SLOT_W-1:0];
  end
endmodule

// File: rtl/gfx_cfg_dpath.sv
module gfx_cfg_dpath
  import gfx_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] idxRdata,
  output logic              errSticky
);
  logic [DATA_W-1:0] bank [NUM_REGS];
  logic [DATA_W-1:0] oldWord;

  assign oldWord = bank[strobe.wrSlot];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else if (strobe.wrEn) begin
      bank[strobe.wrSlot] <= (oldWord & ~strobe.wrMask) |
                             (strobe.wrData & strobe.wrMask);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              errSticky <= 1'b0;
    else if (strobe.errSet) errSticky <= 1'b1;
    else if (strobe.errClr) errSticky <= 1'b0;
  end

  always_comb begin
    busRdata = strobe.busRdEn ? bank[strobe.busRdSlot] : '0;
    idxRdata = strobe.idxRdEn ? bank[strobe.idxRdSlot] : '0;
  end
endmodule

// File: rtl/gfx_cfg_regfile.sv
module gfx_cfg_regfile
  import gfx_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  output logic              busReady,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr,
  input  logic              idxValid,
  output logic              idxReady,
  input  logic              idxWrite,
  input  logic [IDX_W-1:0]  idxIndex,
  input  logic [DATA_W-1:0] idxMask,
  input  logic [DATA_W-1:0] idxWdata,
  output logic [DATA_W-1:0] idxRdata,
  input  logic              errClr,
  output logic              errSticky
);
  cfgStrobe_t strobe;

  gfx_cfg_ctrl uCtrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busReady (busReady),
    .busErr   (busErr),
    .idxValid (idxValid),
    .idxWrite (idxWrite),
    .idxIndex (idxIndex),
    .idxMask  (idxMask),
    .idxWdata (idxWdata),
    .idxReady (idxReady),
    .errClr   (errClr),
    .strobe   (strobe)
  );

  gfx_cfg_dpath uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busRdata  (busRdata),
    .idxRdata  (idxRdata),
    .errSticky (errSticky)
  );
endmodule

// File: rtl/gfx_cfg_regfile_chk.sv
module gfx_cfg_regfile_chk
  import gfx_cfg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busReady,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic              busErr,
  input logic              idxValid,
  input logic              idxReady,
  input logic              idxWrite,
  input logic [IDX_W-1:0]  idxIndex,
  input logic [DATA_W-1:0] idxRdata,
  input logic              errClr,
  input logic              errSticky
);
  logic outWin;
  logic idxOor;
  logic anySet;

  assign outWin = (busAddr < WIN_BASE) || (busAddr >= WIN_BASE + WIN_BYTES);
  assign idxOor = idxIndex >= IDX_W'(NUM_REGS);
  assign anySet = (idxValid && idxWrite && idxOor) ||
                  (busValid && busReady && busWrite && outWin);

  AST_OUT_WIN_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    busValid && outWin |-> busErr && busRdata == '0); // R4
  AST_IN_WIN_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !outWin |-> !busErr); // R2
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    idxValid && idxOor |-> idxRdata == '0); // R6
  AST_OOR_WRITE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    idxValid && idxWrite && idxOor |=> errSticky); // R6
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    errSticky && !errClr |=> errSticky); // R7
  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    errClr && !anySet |=> !errSticky); // R7
  AST_STICKY_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !errSticky && !anySet |=> !errSticky); // R9
  AST_BUS_STALL: assert property (@(posedge clk) disable iff (!rstN)
    busReady == !(idxValid && idxWrite)); // R9
  AST_IDX_READY: assert property (@(posedge clk) disable iff (!rstN)
    idxReady); // R9
endmodule

bind gfx_cfg_regfile gfx_cfg_regfile_chk uChk (.*);

// File: tb/gfx_cfg_regfile_test.sv
`timescale 1ns/1ps
module gfx_cfg_regfile_test;
  localparam logic [31:0] BASE = 32'h1EF0_1000;
  localparam int          NREG = 768;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 0, busWrite = 0, idxValid = 0, idxWrite = 0, errClr = 0;
  logic [31:0] busAddr = 0, busWdata = 0, idxMask = 0, idxWdata = 0;
  logic [11:0] idxIndex = 0;
  logic        busReady, busErr, idxReady, errSticky;
  logic [31:0] busRdata, idxRdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [NREG];
  logic        modelErr;

  always #2.5 clk = ~clk;

  gfx_cfg_regfile uut (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busReady(busReady), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr),
    .idxValid(idxValid), .idxReady(idxReady), .idxWrite(idxWrite),
    .idxIndex(idxIndex), .idxMask(idxMask), .idxWdata(idxWdata), .idxRdata(idxRdata),
    .errClr(errClr), .errSticky(errSticky)
  );

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit bv, bit bw, logic [31:0] ba, logic [31:0] bd,
                      bit iv, bit iw, logic [11:0] ii, logic [31:0] im,
                      logic [31:0] id, bit clr);
    bit inWin, rdy, idxOk, setE;
    int bIdx;
    @(negedge clk);
    busValid = bv; busWrite = bw; busAddr = ba; busWdata = bd;
    idxValid = iv; idxWrite = iw; idxIndex = ii; idxMask = im; idxWdata = id;
    errClr = clr;
    #1;
    inWin = (ba >= BASE) && (ba < BASE + 32'hC00);
    bIdx  = inWin ? int'((ba - BASE) >> 2) : 0;
    idxOk = ii < NREG;
    rdy   = !(iv && iw);
    cmp(tag, "busReady", {31'd0, busReady}, {31'd0, rdy});
    cmp(tag, "idxReady", {31'd0, idxReady}, 32'd1);
    cmp(tag, "busErr", {31'd0, busErr}, {31'd0, bv && !inWin});
    cmp(tag, "busRdata", busRdata, (bv && inWin) ? model[bIdx] : 32'd0);
    cmp(tag, "idxRdata", idxRdata, (iv && idxOk) ? model[ii] : 32'd0);
    cmp(tag, "errSticky", {31'd0, errSticky}, {31'd0, modelErr});
    setE = (iv && iw && !idxOk) || (bv && bw && rdy && !inWin);
    @(posedge clk);
    if (iv && iw && idxOk) model[ii] = (model[ii] & ~im) | (id & im);
    else if (bv && bw && rdy && inWin) model[bIdx] = bd;
    if (setE) modelErr = 1'b1;
    else if (clr) modelErr = 1'b0;
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    busValid = 0; idxValid = 0; errClr = 0;
    repeat (2) @(posedge clk);
    for (int i = 0; i < NREG; i++) model[i] = 32'd0;
    modelErr = 1'b0;
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] ra;
    doReset();
    // R1: reset state, probed at both ends of the bank
    step("R1", 1, 0, BASE, 0, 1, 0, 12'd0, 0, 0, 0);
    step("R1", 1, 0, BASE + 32'hBFC, 0, 1, 0, 12'd767, 0, 0, 0);
    // R2: full-word bus writes at window edges, low bits ignored
    step("R2", 1, 1, BASE, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 1, BASE + 32'hBFF, 32'h1234_5678, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 1, BASE + 32'h402, 32'hA5A5_0F0F, 0, 0, 0, 0, 0, 0);
    // R3: read back through both ports
    step("R3", 1, 0, BASE + 32'h3, 0, 1, 0, 12'd767, 0, 0, 0);
    step("R3", 1, 0, BASE + 32'h400, 0, 1, 0, 12'd256, 0, 0, 0);
    // R4: outside the window, just below and at the end
    step("R4", 1, 0, BASE - 32'd4, 0, 0, 0, 0, 0, 0, 0);
    step("R4", 1, 1, BASE + 32'hC00, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
    step("R4", 1, 0, BASE + 32'hC00, 0, 1, 0, 12'd0, 0, 0, 0);
    // R7: clear, then hold
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle("R7");
    // R5: masked merges with zero, byte and scattered masks
    step("R5", 0, 0, 0, 0, 1, 1, 12'd5, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 0);
    step("R5", 0, 0, 0, 0, 1, 1, 12'd5, 32'h0000_0000, 32'hFFFF_FFFF, 0);
    step("R5", 0, 0, 0, 0, 1, 1, 12'd5, 32'hFF00_00FF, 32'h1122_3344, 0);
    step("R5", 0, 0, 0, 0, 1, 1, 12'd5, 32'h8000_0001, 32'hFFFF_FFFF, 0);
    step("R5", 0, 0, 0, 0, 1, 0, 12'd5, 0, 0, 0);
    // R8: same-cycle read of a written register shows the old value
    step("R8", 1, 0, BASE + 32'h14, 0, 1, 1, 12'd5, 32'hFFFF_FFFF, 32'hCAFE_F00D, 0);
    step("R8", 1, 1, BASE + 32'h14, 32'h0BAD_F00D, 1, 0, 12'd5, 0, 0, 0);
    step("R8", 1, 0, BASE + 32'h14, 0, 0, 0, 0, 0, 0, 0);
    // R6: out-of-range index
    step("R6", 0, 0, 0, 0, 1, 0, 12'd768, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 1, 1, 12'd768, 32'hFFFF_FFFF, 32'h7777_7777, 0);
    step("R6", 0, 0, 0, 0, 1, 1, 12'hFFF, 32'hFFFF_FFFF, 32'h7777_7777, 0);
    // R7: a new error together with clear keeps the flag set
    step("R7", 0, 0, 0, 0, 1, 1, 12'd900, 32'hFFFF_FFFF, 0, 1);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle("R7");
    // R9: index write blocks a bus write, even an out-of-window one
    step("R9", 1, 1, BASE + 32'h20, 32'h5555_5555, 1, 1, 12'd9, 32'hFFFF_FFFF, 32'h9999_9999, 0);
    step("R9", 1, 1, BASE - 32'd16, 32'h5555_5555, 1, 1, 12'd10, 32'hFFFF_FFFF, 32'h1010_1010, 0);
    step("R9", 1, 0, BASE + 32'h20, 0, 1, 0, 12'd8, 0, 0, 0);
    // Mixed traffic across all behaviours
    for (int n = 0; n < 1500; n++) begin
      case ($urandom % 4)
        0: ra = BASE + ($urandom % 32'hC00);
        1: ra = BASE + 32'hC00 + ($urandom % 64);
        2: ra = BASE - 1 - ($urandom % 64);
        default: ra = BASE + (($urandom % 8) << 2);
      endcase
      step("R5", $urandom % 2, $urandom % 2, ra, $urandom,
           $urandom % 2, $urandom % 2, 12'(($urandom % 2) ? ($urandom % 8) : ($urandom % 800)),
           $urandom, $urandom, ($urandom % 8) == 0);
    end
    // R1: a later reset clears everything again
    doReset();
    step("R1", 1, 0, BASE + 32'h14, 0, 1, 0, 12'd5, 0, 0, 0);
    step("R1", 1, 0, BASE, 0, 1, 0, 12'd9, 0, 0, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule